// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block is a watchdog for a system that runs from a 32.768 kHz counting clock. Software programs a timeout in half-second units and then sets the enable bit. From then on a down-counter runs. If software does not service the watchdog in time, the block pulses a system reset and, if configured, drives an external reset line. A separate interrupt can warn software a programmable number of half-second units before the reset fires. Servicing needs two specific words written in order, so a stray single write cannot keep a runaway system alive.

The block has a 16-bit synchronous register port. A write happens on the clock edge where the write strobe is high. A read is combinational from the address. Each of three mode inputs (wait, debug and low-power) can freeze the countdown, and a control bit for each mode selects whether that input has any effect. The enable bit cannot be cleared once set; only the power-on reset input clears it.

Top module: `wdtTop`

## Requirements
- R1: After power-on reset the registers read as follows: control (offset 0x0) is 0x0030, interrupt control (0x6) is 0x0000, misc (0x8) is 0x0000 and reset status (0x4) is 0x0010. At the same time irq is 0, sysRst is 0 and extRstN is 1.
- R2: Control bit 2 is the enable. Writing it 1 starts counting. Once it is set, writing 0 to it leaves it reading 1.
- R3: With timeout field W (control bits 15:8), the first expiry occurs on the edge that lies (W+1)×TICKS_PER_UNIT edges after the enabling write edge. sysRst is high for exactly that one cycle. The counter then reloads, so the next expiry follows after the same period.
- R4: Writing 0x5555 and then 0xAAAA to the service register (offset 0x2) reloads the counter on the edge of the 0xAAAA write. The next expiry then comes a full period after that edge.
- R5: A service sequence broken by any other word, or an 0xAAAA write not preceded by 0x5555, does not reload the counter. Writing 0x5555 always restarts the sequence at its second step.
- R6: Interrupt-control bits 7:0 hold a lead L, with 1 ≤ L ≤ W. Status bit 14 sets L×TICKS_PER_UNIT edges before the expiry edge. irq equals bit 15 (interrupt enable) AND bit 14. Writing 1 to bit 14 clears it.
- R7: While control bit 7, 1 or 0 is set and the matching waitIn, dbgIn or lpIn input is high, the count does not advance, so expiry is delayed by one edge per frozen edge. A mode input whose bit is clear has no effect.
- R8: A control write with bit 4 = 0 raises sysRst for one cycle, starting at that write edge, and sets reset status to 0x0001. Bit 4 always reads 1.
- R9: Reset status is one-hot. Power-on reset sets it to 0x0010 (bit 4). A watchdog expiry sets it to 0x0002 (bit 1). A soft reset request sets it to 0x0001 (bit 0).
- R10: extRstN is low while control bit 5 is 0. When bit 3 is 1, extRstN is also low during the cycle in which sysRst reports an expiry.
- R11: Misc register bit 0 is read/write and reads back alone. The service register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rstN | input | 1 | Power-on reset, active low |
| busWr | input | 1 | Write strobe, sampled at the clock edge |
| busAddr | input | 4 | Byte offset of the register |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for busAddr |
| waitIn | input | 1 | System is in wait mode |
| dbgIn | input | 1 | System is halted in debug |
| lpIn | input | 1 | System is in low-power mode |
| irq | output | 1 | Pre-timeout interrupt |
| sysRst | output | 1 | One-cycle system reset pulse |
| extRstN | output | 1 | External reset, active low |

## Verification
The hardest case to reach is the pre-timeout flag followed by expiry, measured against an exact edge count. The count is only visible through the timing of sysRst and irq. The bench therefore shortens the half-second unit through the parameter and counts edges from the enabling write. Service sequences and suspend windows are placed at known edge numbers, so each shift of the expiry edge is checked exactly. A broken service sequence is checked by showing that the original expiry edge still arrives.

// File: rtl/wdtPkg.sv
package wdtPkg;
  localparam int UNIT_W = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_INTC = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_MISC = 4'h8;

  localparam logic [DATA_W-1:0] SVC_KEY_A = 16'h5555;
  localparam logic [DATA_W-1:0] SVC_KEY_B = 16'hAAAA;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic              load;
    logic              run;
    logic [UNIT_W-1:0] loadVal;
    logic [UNIT_W-1:0] leadVal;
  } cntStrobe_t;
endpackage

// File: rtl/wdtCount.sv
module wdtCount
  import wdtPkg::*;
#(
  parameter int TICKS = 16384,
  localparam int PSW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  output logic       expireEv,
  output logic       leadEv
);
  localparam logic [PSW-1:0] PRE_TOP = PSW'(TICKS - 1);

  logic [UNIT_W-1:0] unitCnt;
  logic [PSW-1:0]    preCnt;
  logic              unitWrap;

  assign unitWrap = strobe.run && !strobe.load && (preCnt == '0);
  assign expireEv = unitWrap && (unitCnt == '0);
  assign leadEv   = unitWrap && (unitCnt != '0) && (unitCnt == strobe.leadVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitCnt <= '0;
      preCnt  <= PRE_TOP;
    end else if (strobe.load) begin
      unitCnt <= strobe.loadVal;
      preCnt  <= PRE_TOP;
    end else if (strobe.run) begin
      if (preCnt == '0) begin
        preCnt <= PRE_TOP;
        if (unitCnt == '0) unitCnt <= strobe.loadVal;
        else               unitCnt <= unitCnt - 1'b1;
      end else begin
        preCnt <= preCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdtCtrl.sv
module wdtCtrl
  import wdtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic              waitIn,
  input  logic              dbgIn,
  input  logic              lpIn,
  input  logic              expireEv,
  input  logic              leadEv,
  output cntStrobe_t        strobe,
  output logic              irq,
  output logic              sysRst,
  output logic              extRstN
);
  localparam int NMODE = 3;

  logic [UNIT_W-1:0] toutQ;
  logic waitSelQ, dbgSelQ, lpSelQ;
  logic extHoldNQ, extOnToQ, wdeQ;
  logic intEnQ, intStsQ;
  logic [UNIT_W-1:0] leadQ;
  logic miscQ;
  logic [2:0] rsrQ;  // {power-on, timeout, soft}
  logic svcArmedQ;
  logic sysRstQ, toPulseQ;

  logic ctrlWr, svcWr, intcWr, miscWr;
  logic softReq, enLoad, svcDone;
  logic [NMODE-1:0] modeSel, modeIn, modeHit;
  logic suspend;

  assign ctrlWr = busWr && (busAddr == OFF_CTRL);
  assign svcWr  = busWr && (busAddr == OFF_SVC);
  assign intcWr = busWr && (busAddr == OFF_INTC);
  assign miscWr = busWr && (busAddr == OFF_MISC);

  assign softReq = ctrlWr && !busWData[4];
  assign enLoad  = ctrlWr && busWData[2] && !wdeQ;
  assign svcDone = svcWr && svcArmedQ && (busWData == SVC_KEY_B);

  assign modeSel = {waitSelQ, dbgSelQ, lpSelQ};
  assign modeIn  = {waitIn, dbgIn, lpIn};

  for (genvar m = 0; m < NMODE; m++) begin : gMode
    assign modeHit[m] = modeSel[m] & modeIn[m];
  end

  assign suspend = |modeHit;

  always_comb begin
    strobe.load    = enLoad || (svcDone && wdeQ);
    strobe.run     = wdeQ && !suspend;
    strobe.loadVal = enLoad ? busWData[15:8] : toutQ;
    strobe.leadVal = leadQ;
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toutQ     <= '0;
      waitSelQ  <= 1'b0;
      dbgSelQ   <= 1'b0;
      lpSelQ    <= 1'b0;
      extHoldNQ <= 1'b1;
      extOnToQ  <= 1'b0;
      wdeQ      <= 1'b0;
    end else if (ctrlWr) begin
      toutQ     <= busWData[15:8];
      waitSelQ  <= busWData[7];
      extHoldNQ <= busWData[5];
      extOnToQ  <= busWData[3];
      wdeQ      <= wdeQ | busWData[2];
      dbgSelQ   <= busWData[1];
      lpSelQ    <= busWData[0];
    end
  end

  // interrupt control and misc
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ  <= 1'b0;
      intStsQ <= 1'b0;
      leadQ   <= '0;
      miscQ   <= 1'b0;
    end else begin
      if (intcWr) begin
        intEnQ <= busWData[15];
        leadQ  <= busWData[7:0];
      end
      if (leadEv)                      intStsQ <= 1'b1;
      else if (intcWr && busWData[14]) intStsQ <= 1'b0;
      if (miscWr) miscQ <= busWData[0];
    end
  end

  // service sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      svcArmedQ <= 1'b0;
    else if (svcWr) svcArmedQ <= (busWData == SVC_KEY_A);
  end

  // reset cause and output pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsrQ     <= 3'b100;
      sysRstQ  <= 1'b0;
      toPulseQ <= 1'b0;
    end else begin
      if (softReq)       rsrQ <= 3'b001;
      else if (expireEv) rsrQ <= 3'b010;
      sysRstQ  <= expireEv | softReq;
      toPulseQ <= expireEv;
    end
  end

  assign irq     = intEnQ & intStsQ;
  assign sysRst  = sysRstQ;
  assign extRstN = extHoldNQ & ~(toPulseQ & extOnToQ);

  always_comb begin
    busRData = '0;
    case (busAddr)
      OFF_CTRL: busRData = {toutQ, waitSelQ, 1'b0, extHoldNQ, 1'b1,
                            extOnToQ, wdeQ, dbgSelQ, lpSelQ};
      OFF_STAT: busRData = {11'd0, rsrQ[2], 2'b00, rsrQ[1], rsrQ[0]};
      OFF_INTC: busRData = {intEnQ, intStsQ, 6'd0, leadQ};
      OFF_MISC: busRData = {15'd0, miscQ};
      default:  busRData = '0;
    endcase
  end
endmodule

// File: rtl/wdtTop.sv
module wdtTop
  import wdtPkg::*;
#(
  parameter int TICKS_PER_UNIT = 16384
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [3:0]  busAddr,
  input  logic [15:0] busWData,
  output logic [15:0] busRData,
  input  logic        waitIn,
  input  logic        dbgIn,
  input  logic        lpIn,
  output logic        irq,
  output logic        sysRst,
  output logic        extRstN
);
  cntStrobe_t strobe;
  logic       expireEv;
  logic       leadEv;

  wdtCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .waitIn(waitIn),
    .dbgIn(dbgIn), .lpIn(lpIn), .expireEv(expireEv), .leadEv(leadEv),
    .strobe(strobe), .irq(irq), .sysRst(sysRst), .extRstN(extRstN)
  );

  wdtCount #(.TICKS(TICKS_PER_UNIT)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .expireEv(expireEv), .leadEv(leadEv)
  );
endmodule

// File: rtl/wdtChecker.sv
module wdtChecker
  import wdtPkg::*;
#(
  parameter int TICKS = 16384,
  localparam int PSW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input cntStrobe_t        strobe,
  input logic              expireEv,
  input logic              leadEv,
  input logic              sysRst,
  input logic              wde,
  input logic [2:0]        rsr,
  input logic [UNIT_W-1:0] unitCnt,
  input logic [PSW-1:0]    preCnt
);
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN) wde |=> wde); // R2
  AST_EXPIRE_TO_RESET: assert property (@(posedge clk) disable iff (!rstN) expireEv |=> sysRst); // R3
  AST_NO_EXPIRE_OFF: assert property (@(posedge clk) disable iff (!rstN) !wde |-> !expireEv); // R3
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (unitCnt == $past(strobe.loadVal)) && (preCnt == PSW'(TICKS - 1))); // R4
  AST_LEAD_APART: assert property (@(posedge clk) disable iff (!rstN) !(leadEv && expireEv)); // R6
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.load) |=> ($stable(unitCnt) && $stable(preCnt))); // R7
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $countones(rsr) == 1); // R9
endmodule

bind wdtTop wdtChecker #(.TICKS(TICKS_PER_UNIT)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .expireEv(expireEv),
  .leadEv(leadEv), .sysRst(sysRst), .wde(u_ctrl.wdeQ), .rsr(u_ctrl.rsrQ),
  .unitCnt(u_count.unitCnt), .preCnt(u_count.preCnt)
);

// File: tb/wdtTop_tb.sv
module wdtTop_tb;
  localparam int T = 16;
  localparam int N = 3 * T;  // timeout field 2

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        waitIn = 1'b0, dbgIn = 1'b0, lpIn = 1'b0;
  logic        irq, sysRst, extRstN;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdtTop #(.TICKS_PER_UNIT(T)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .waitIn(waitIn),
    .dbgIn(dbgIn), .lpIn(lpIn), .irq(irq), .sysRst(sysRst), .extRstN(extRstN)
  );

  // {req, write, addr, data, expected read}
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1,  1'b0, 4'h0, 16'h0000, 16'h0030},  // R1 control reset
    {4'd1,  1'b0, 4'h4, 16'h0000, 16'h0010},  // R1 status reset
    {4'd9,  1'b0, 4'h4, 16'h0000, 16'h0010},  // R9 power-on cause
    {4'd1,  1'b0, 4'h6, 16'h0000, 16'h0000},  // R1 intc reset
    {4'd1,  1'b0, 4'h8, 16'h0000, 16'h0000},  // R1 misc reset
    {4'd2,  1'b1, 4'h0, 16'h12B3, 16'h0000},  // R2 write control, enable clear
    {4'd2,  1'b0, 4'h0, 16'h0000, 16'h12B3},  // R2 fields read back
    {4'd6,  1'b1, 4'h6, 16'hC005, 16'h0000},  // R6 write intc
    {4'd6,  1'b0, 4'h6, 16'h0000, 16'h8005},  // R6 status not settable
    {4'd11, 1'b1, 4'h8, 16'hFFFF, 16'h0000},  // R11 write misc
    {4'd11, 1'b0, 4'h8, 16'h0000, 16'h0001},  // R11 only bit 0
    {4'd11, 1'b0, 4'h2, 16'h0000, 16'h0000},  // R11 service reads 0
    {4'd11, 1'b0, 4'hA, 16'h0000, 16'h0000}   // R11 unmapped reads 0
  };

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d at cyc %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    busWr = 1'b1; busAddr = a; busWData = d;
    tick();
    busWr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [3:0] a, input logic [15:0] exp);
    busAddr = a;
    #1;
    chk(req, busRData, exp);
  endtask

  task automatic waitTo(input int target);
    while (cyc < target) tick();
  endtask

  task automatic doReset();
    rstN = 1'b0; busWr = 1'b0; waitIn = 1'b0; dbgIn = 1'b0; lpIn = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 output levels after reset
    chk(1, {15'd0, irq}, 16'd0);
    chk(1, {15'd0, sysRst}, 16'd0);
    chk(1, {15'd0, extRstN}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:16]);
      else            rd(int'(VEC[i][40:37]), VEC[i][35:32], VEC[i][15:0]);
    end

    // R3 / R9 / R10: periodic expiry with external reset
    doReset();
    wr(4'h0, 16'h023C); cyc = 0;
    waitTo(N - 1); chk(3, {15'd0, sysRst}, 16'd0);
    tick();        chk(3, {15'd0, sysRst}, 16'd1);
    chk(10, {15'd0, extRstN}, 16'd0);
    rd(9, 4'h4, 16'h0002);
    tick();        chk(3, {15'd0, sysRst}, 16'd0);
    chk(10, {15'd0, extRstN}, 16'd1);
    waitTo(2 * N - 1); chk(3, {15'd0, sysRst}, 16'd0);
    tick();            chk(3, {15'd0, sysRst}, 16'd1);
    wr(4'h0, 16'h0038);
    rd(2, 4'h0, 16'h003C);  // R2 enable stays set

    // R6: pre-timeout interrupt, lead 1
    doReset();
    wr(4'h6, 16'h8001);
    wr(4'h0, 16'h0234); cyc = 0;
    waitTo(2 * T - 1); chk(6, {15'd0, irq}, 16'd0);
    tick();            chk(6, {15'd0, irq}, 16'd1);
    rd(6, 4'h6, 16'hC001);
    wr(4'h6, 16'hC001);
    chk(6, {15'd0, irq}, 16'd0);
    waitTo(N - 1); chk(3, {15'd0, sysRst}, 16'd0);
    tick();        chk(3, {15'd0, sysRst}, 16'd1);
    chk(10, {15'd0, extRstN}, 16'd1);  // R10 bit 3 clear

    // R4 / R5: service sequences
    doReset();
    wr(4'h0, 16'h0234); cyc = 0;
    waitTo(20);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);  // reload at edge 22
    waitTo(N); chk(4, {15'd0, sysRst}, 16'd0);
    waitTo(22 + N - 1); chk(4, {15'd0, sysRst}, 16'd0);
    tick();             chk(4, {15'd0, sysRst}, 16'd1);
    waitTo(80);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    waitTo(100);
    wr(4'h2, 16'hAAAA);
    waitTo(22 + 2 * N - 1); chk(5, {15'd0, sysRst}, 16'd0);
    tick();                 chk(5, {15'd0, sysRst}, 16'd1);

    // R7: low-power freeze, debug input without its bit ignored
    doReset();
    wr(4'h0, 16'h0235); cyc = 0;
    waitTo(10); lpIn = 1'b1;
    waitTo(20); lpIn = 1'b0;
    waitTo(30); dbgIn = 1'b1; waitIn = 1'b1;
    waitTo(40); dbgIn = 1'b0; waitIn = 1'b0;
    waitTo(N); chk(7, {15'd0, sysRst}, 16'd0);
    waitTo(N + 10 - 1); chk(7, {15'd0, sysRst}, 16'd0);
    tick();             chk(7, {15'd0, sysRst}, 16'd1);

    // R8 / R10: soft reset request and external hold
    doReset();
    wr(4'h0, 16'h0020);
    chk(8, {15'd0, sysRst}, 16'd1);
    rd(8, 4'h4, 16'h0001);
    rd(8, 4'h0, 16'h0030);
    tick();
    chk(8, {15'd0, sysRst}, 16'd0);
    wr(4'h0, 16'h0010);
    chk(10, {15'd0, extRstN}, 16'd0);
    chk(8, {15'd0, sysRst}, 16'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule